// File: doc/BRIEF.md
# Lockable SMM Memory Access Decoder

This block holds the configuration that defines system-management-mode memory and routes every memory access to one of three targets: DRAM, the internal graphics device, or the hub interface. Three regions are decoded. The first is the legacy graphics window at 000A0000–000BFFFF. The second is a high remap window at FEEA0000–FEEBFFFF. The third is a stolen segment just below the top of memory (TOM), sized 512 KB or 1 MB. Each access presents its attributes to the router, which decides the target in the same cycle:

- address;
- whether it comes from the processor;
- read or write;
- code or data;
- whether it is made in SMM;
- whether it is an explicit write-back.

A small configuration register controls the decode. It holds an upper-region select, a lower-segment select, a lock bit and a sticky error flag, and it is written through a single-cycle config-write strobe. Firmware normally opens the legacy segment as plain RAM to initialise SMM space and then sets the lock. After that, the lock bit, the upper select and the top bit of the lower select can no longer be changed until reset. The error flag records any processor access outside SMM that touches the stolen segment or the high window.

Top module: `smm_access_ctrl`

## Requirements
- R1: After a synchronous active-low reset the register reads all zeros. The read layout is [5:4] upper select, [3:2] lower select, [1] lock, [0] error.
- R2: While unlocked, a config write loads the upper select, the lower select and the lock bit from the write data. The new values appear on the read port after the next rising clock edge.
- R3: Once the lock reads 1, writes do not change the lock bit, the upper select or lower-select bit 3. Only reset clears the lock.
- R4: While locked, lower-select bit 2 follows a write only when lower-select bit 3 is currently 1. Otherwise bit 2 keeps its value.
- R5: The error bit sets on the edge after a valid access that meets all of the following: it comes from the processor, it is made outside SMM, it is not a write-back, and it hits the active stolen segment or the active high window. Writing 1 to bit 0 clears the error bit. If a set and a clear fall in the same cycle, the set wins.
- R6: Upper select 10 makes [TOM−512 KB, TOM) the stolen segment, and 11 makes [TOM−1 MB, TOM) the stolen segment. Upper select 00 or 01 leaves no stolen segment. A processor access in SMM to the stolen segment routes to DRAM (code 00). Any other access to it routes to the hub (code 10).
- R7: The high window FEEA0000–FEEBFFFF is active only when the upper select is not 00 and the lower select is 00. When it is active, a processor access in SMM routes to DRAM and any other access routes to the hub.
- R8: In the legacy window, lower select 00 never routes to DRAM. Lower select 01 routes every access to DRAM. Lower select 10 routes only processor SMM code reads to DRAM. Lower select 11 routes every processor SMM access to DRAM.
- R9: A legacy-window access that is not served by DRAM routes to graphics (code 01) when the graphics-enable input is 1, and to the hub otherwise.
- R10: Any other address routes to DRAM when it is below TOM and to the hub otherwise. Route code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_wdata | input | 6 | Config write data, same layout as the read port |
| cfg_rdata | output | 6 | Current register contents |
| acc_valid | input | 1 | An access is present this cycle |
| acc_from_cpu | input | 1 | Access issued by the processor |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_code | input | 1 | 1 = code fetch, 0 = data |
| acc_smm | input | 1 | Processor is in SMM |
| acc_wb | input | 1 | Explicit write-back |
| tom | input | ADDR_W | Top of memory, at least 1 MB |
| gfx_en | input | 1 | Internal graphics device enabled |
| acc_route | output | 2 | 00 DRAM, 01 graphics, 10 hub |

## Verification
The bench uses the default parameters: a 32-bit address, 512 KB and 1 MB stolen-segment sizes, and the fixed legacy and high windows. It drives TOM at 0x1000_0000, so both stolen-segment sizes and the windows sit well apart. Addresses are drawn from the window edges, from points one byte inside and outside each boundary, and from the span down to 1.25 MB below TOM. This puts every region boundary and both segment sizes within reach. Separate lock scenarios start from lower select 10 and from lower select 01, which exercises both branches of the guarded bit-2 write. A further scenario drives a set and a clear of the error flag in the same cycle.

// File: rtl/smm_pkg.sv
// Package: shared types for the SMM access decoder.
// Assumes a 6-bit config register whose field order is the read-port layout.
package smm_pkg;

    typedef enum logic [1:0] {
        RT_DRAM = 2'b00,
        RT_GFX  = 2'b01,
        RT_HUB  = 2'b10
    } route_e;

    typedef struct packed {
        logic [1:0] upper;  // stolen segment / high window select
        logic [1:0] lower;  // legacy window mode
        logic       lock;   // sticky lock
        logic       err;    // sticky non-SMM hit flag
    } smm_cfg_t;

    localparam int CFG_W = $bits(smm_cfg_t);

endpackage

// File: rtl/smm_cfg_reg.sv
// Module: configuration register with lock protection and a sticky error flag.
// Assumes a synchronous active-low reset. A write and a hardware set may coincide;
// the set wins on the error bit.
module smm_cfg_reg
    import smm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    input  logic             err_set,
    output smm_cfg_t         cfg
);

    smm_cfg_t wr_view;
    smm_cfg_t cfg_nxt;

    assign wr_view = smm_cfg_t'(wdata);

    // Next-state: field writes gated by the lock, W1C error, set has priority.
    always_comb begin
        cfg_nxt = cfg;
        if (wr_en) begin
            if (!cfg.lock) begin
                cfg_nxt.upper = wr_view.upper;
                cfg_nxt.lower = wr_view.lower;
                cfg_nxt.lock  = wr_view.lock;
            end else if (cfg.lower[1]) begin
                cfg_nxt.lower[0] = wr_view.lower[0];
            end
            if (wr_view.err) begin
                cfg_nxt.err = 1'b0;
            end
        end
        if (err_set) begin
            cfg_nxt.err = 1'b1;
        end
    end

    // State register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            cfg <= cfg_nxt;
        end
    end

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> cfg.lock);
    p_upper_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> $stable(cfg.upper));
    p_bit3_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lock |=> $stable(cfg.lower[1]));
    p_bit2_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.lock && !cfg.lower[1]) |=> $stable(cfg.lower[0]));
    p_err_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> cfg.err);

endmodule

// File: rtl/smm_region_decode.sv
// Module: address window decode for the legacy window, the high remap window and
// the stolen segment below TOM. Assumes TOM is at least the large segment size.
module smm_region_decode #(
    parameter int          ADDR_W      = 32,
    parameter longint      LEG_BASE    = 64'h000A_0000,
    parameter longint      LEG_BYTES   = 64'h0002_0000,
    parameter longint      HI_BASE     = 64'hFEEA_0000,
    parameter longint      HI_BYTES    = 64'h0002_0000,
    parameter int unsigned SEG_SMALL_KB = 512,
    parameter int unsigned SEG_LARGE_KB = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] tom,
    input  logic [1:0]        upper,
    input  logic [1:0]        lower,
    output logic              leg_hit,
    output logic              hi_hit,
    output logic              seg_hit,
    output logic              below_tom
);

    localparam logic [ADDR_W-1:0] LEG_LO = ADDR_W'(LEG_BASE);
    localparam logic [ADDR_W-1:0] LEG_HI = ADDR_W'(LEG_BASE + LEG_BYTES - 1);
    localparam logic [ADDR_W-1:0] HI_LO  = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_HI  = ADDR_W'(HI_BASE + HI_BYTES - 1);
    localparam logic [ADDR_W-1:0] SEG_SM = ADDR_W'(longint'(SEG_SMALL_KB) * 1024);
    localparam logic [ADDR_W-1:0] SEG_LG = ADDR_W'(longint'(SEG_LARGE_KB) * 1024);

    logic              hi_enabled;
    logic              seg_enabled;
    logic [ADDR_W-1:0] seg_size;
    logic [ADDR_W-1:0] seg_floor;

    // Region enables derived from the select fields.
    always_comb begin
        hi_enabled  = (upper != 2'b00) && (lower == 2'b00);
        seg_enabled = upper[1];
        seg_size    = upper[0] ? SEG_LG : SEG_SM;
        seg_floor   = tom - seg_size;
    end

    // Window compares.
    always_comb begin
        below_tom = addr < tom;
        leg_hit   = (addr >= LEG_LO) && (addr <= LEG_HI);
        hi_hit    = hi_enabled && (addr >= HI_LO) && (addr <= HI_HI);
        seg_hit   = seg_enabled && (addr >= seg_floor) && below_tom;
    end

endmodule

// File: rtl/smm_router.sv
// Module: picks the target of an access from the region hits and its attributes,
// and raises the error event for a non-SMM processor hit on an extended region.
// Assumes the three windows do not overlap; the legacy window is checked first.
module smm_router
    import smm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       from_cpu,
    input  logic       is_write,
    input  logic       is_code,
    input  logic       in_smm,
    input  logic       is_wb,
    input  logic       gfx_en,
    input  logic [1:0] lower,
    input  logic       leg_hit,
    input  logic       hi_hit,
    input  logic       seg_hit,
    input  logic       below_tom,
    output route_e     route,
    output logic       err_evt
);

    logic   cpu_smm;
    logic   leg_dram;
    route_e leg_alt;

    // Legacy window policy per lower-select mode.
    always_comb begin
        cpu_smm = from_cpu && in_smm;
        unique case (lower)
            2'b00:   leg_dram = 1'b0;
            2'b01:   leg_dram = 1'b1;
            2'b10:   leg_dram = cpu_smm && is_code && !is_write;
            default: leg_dram = cpu_smm;
        endcase
        leg_alt = gfx_en ? RT_GFX : RT_HUB;
    end

    // Target selection in window priority order.
    always_comb begin
        if (leg_hit) begin
            route = leg_dram ? RT_DRAM : leg_alt;
        end else if (hi_hit || seg_hit) begin
            route = cpu_smm ? RT_DRAM : RT_HUB;
        end else begin
            route = below_tom ? RT_DRAM : RT_HUB;
        end
    end

    // Error event for processor non-SMM touches of extended regions.
    always_comb begin
        err_evt = acc_valid && from_cpu && !in_smm && !is_wb && !leg_hit
                  && (hi_hit || seg_hit);
    end

    p_ext_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!leg_hit && (hi_hit || seg_hit) && !cpu_smm) |-> route == RT_HUB);
    p_leg_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_hit && lower == 2'b00) |-> route != RT_DRAM);
    p_code_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_hit && lower == 2'b10 && (is_write || !is_code)) |-> route != RT_DRAM);
    p_no_code11_r10: assert property (@(posedge clk) disable iff (!rst_n)
        route != 2'b11);

endmodule

// File: rtl/smm_access_ctrl.sv
// Module: top of the SMM access decoder. It ties the config register, the
// window decode and the router together. Routing is combinational; register
// updates land on the edge after the strobe.
module smm_access_ctrl
    import smm_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int unsigned SEG_SMALL_KB = 512,
    parameter int unsigned SEG_LARGE_KB = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_wdata,
    output logic [5:0]        cfg_rdata,
    input  logic              acc_valid,
    input  logic              acc_from_cpu,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_code,
    input  logic              acc_smm,
    input  logic              acc_wb,
    input  logic [ADDR_W-1:0] tom,
    input  logic              gfx_en,
    output logic [1:0]        acc_route
);

    smm_cfg_t cfg;
    logic     err_evt;
    logic     leg_hit;
    logic     hi_hit;
    logic     seg_hit;
    logic     below_tom;
    route_e   route;

    smm_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .err_set (err_evt),
        .cfg     (cfg)
    );

    smm_region_decode #(
        .ADDR_W       (ADDR_W),
        .SEG_SMALL_KB (SEG_SMALL_KB),
        .SEG_LARGE_KB (SEG_LARGE_KB)
    ) u_dec (
        .addr      (acc_addr),
        .tom       (tom),
        .upper     (cfg.upper),
        .lower     (cfg.lower),
        .leg_hit   (leg_hit),
        .hi_hit    (hi_hit),
        .seg_hit   (seg_hit),
        .below_tom (below_tom)
    );

    smm_router u_rt (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .from_cpu  (acc_from_cpu),
        .is_write  (acc_write),
        .is_code   (acc_code),
        .in_smm    (acc_smm),
        .is_wb     (acc_wb),
        .gfx_en    (gfx_en),
        .lower     (cfg.lower),
        .leg_hit   (leg_hit),
        .hi_hit    (hi_hit),
        .seg_hit   (seg_hit),
        .below_tom (below_tom),
        .route     (route),
        .err_evt   (err_evt)
    );

    // Output mapping.
    always_comb begin
        cfg_rdata = cfg;
        acc_route = route;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> cfg_rdata == 6'd0);

endmodule

// File: tb/smm_access_ctrl_bench.sv
// Bench: behavioural reference model, compared on every clock at mid-cycle.
module smm_access_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TOM_V = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic [5:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_from_cpu = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_code = 1'b0;
    logic        acc_smm = 1'b0;
    logic        acc_wb = 1'b0;
    logic [31:0] tom = TOM_V;
    logic        gfx_en = 1'b0;
    logic [1:0]  acc_route;

    int checks = 0;
    int failures = 0;
    string phase_tag = "R1";

    int m_up = 0, m_lo = 0, m_lock = 0, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smm_access_ctrl u_smm_access_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_from_cpu(acc_from_cpu),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_code(acc_code),
        .acc_smm(acc_smm), .acc_wb(acc_wb), .tom(tom), .gfx_en(gfx_en),
        .acc_route(acc_route)
    );

    function automatic bit in_leg(input logic [31:0] a);
        return a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
    endfunction

    function automatic bit in_hi(input logic [31:0] a);
        return m_up != 0 && m_lo == 0 && a >= 32'hFEEA_0000 && a <= 32'hFEEB_FFFF;
    endfunction

    function automatic bit in_seg(input logic [31:0] a);
        logic [31:0] sz;
        sz = (m_up == 3) ? 32'h0010_0000 : 32'h0008_0000;
        return m_up >= 2 && a >= tom - sz && a < tom;
    endfunction

    function automatic logic [1:0] model_route();
        bit smm_cpu;
        smm_cpu = acc_from_cpu && acc_smm;
        if (in_leg(acc_addr)) begin
            if (m_lo == 1 || (m_lo == 3 && smm_cpu) ||
                (m_lo == 2 && smm_cpu && acc_code && !acc_write))
                return 2'b00;
            return gfx_en ? 2'b01 : 2'b10;
        end
        if (in_hi(acc_addr) || in_seg(acc_addr)) return smm_cpu ? 2'b00 : 2'b10;
        return (acc_addr < tom) ? 2'b00 : 2'b10;
    endfunction

    function automatic string route_tag();
        if (in_leg(acc_addr)) return (m_lo == 1) ? "R8" : "R9";
        if (in_hi(acc_addr)) return "R7";
        if (in_seg(acc_addr)) return "R6";
        return "R10";
    endfunction

    task automatic check_now();
        logic [1:0] er;
        logic [5:0] ed;
        er = model_route();
        ed = {m_up[1:0], m_lo[1:0], m_lock[0], m_err[0]};
        checks++;
        if (acc_route !== er) begin
            failures++;
            $display("FAIL %s route addr=%h actual=%b expected=%b", route_tag(), acc_addr, acc_route, er);
        end
        checks++;
        if (cfg_rdata !== ed) begin
            failures++;
            $display("FAIL %s cfg actual=%b expected=%b", phase_tag, cfg_rdata, ed);
        end
    endtask

    task automatic model_edge();
        bit set;
        set = acc_valid && acc_from_cpu && !acc_smm && !acc_wb && !in_leg(acc_addr)
              && (in_hi(acc_addr) || in_seg(acc_addr));
        if (cfg_wr) begin
            if (m_lock == 0) begin
                m_up = cfg_wdata[5:4]; m_lo = cfg_wdata[3:2]; m_lock = cfg_wdata[1];
            end else if (m_lo >= 2) begin
                m_lo = 2 + cfg_wdata[2];
            end
            if (cfg_wdata[0]) m_err = 0;
        end
        if (set) m_err = 1;
    endtask

    task automatic step();
        #1;
        check_now();
        model_edge();
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick_addr();
        case ($urandom_range(0, 13))
            0: return 32'h000A_0000 + $urandom_range(0, 32'h1_FFFF);
            1: return 32'hFEEA_0000 + $urandom_range(0, 32'h1_FFFF);
            2: return TOM_V - 1 - $urandom_range(0, 32'h13_FFFF);
            3: return TOM_V + $urandom_range(0, 32'hFFF);
            4: return 32'h0009_FFFF;
            5: return 32'h000C_0000;
            6: return 32'hFEE9_FFFF;
            7: return 32'hFEEC_0000;
            8: return TOM_V - 32'h8_0000;
            9: return TOM_V - 32'h8_0001;
            10: return TOM_V - 32'h10_0000;
            11: return TOM_V - 32'h10_0001;
            12: return TOM_V - 1;
            default: return $urandom;
        endcase
    endfunction

    task automatic rand_acc();
        acc_valid    = ($urandom_range(0, 7) != 0);
        acc_from_cpu = ($urandom_range(0, 3) != 0);
        acc_addr     = pick_addr();
        acc_write    = $urandom_range(0, 1);
        acc_code     = $urandom_range(0, 1);
        acc_smm      = $urandom_range(0, 1);
        acc_wb       = ($urandom_range(0, 5) == 0);
        gfx_en       = $urandom_range(0, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_wr = 1'b0;
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_up = 0; m_lo = 0; m_lock = 0; m_err = 0;
    endtask

    task automatic cfg_write(input logic [5:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        acc_valid = 1'b0;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic run(input int n, input bit allow_lock, input int wr_odds);
        for (int i = 0; i < n; i++) begin
            rand_acc();
            cfg_wr = (wr_odds != 0) && ($urandom_range(1, wr_odds) == 1);
            cfg_wdata = 6'($urandom);
            if (!allow_lock) cfg_wdata[1] = 1'b0;
            step();
        end
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state, legacy window closed -> graphics when enabled
        phase_tag = "R1";
        acc_valid = 1'b1; acc_from_cpu = 1'b1; acc_smm = 1'b1;
        acc_addr = 32'h000A_1000; gfx_en = 1'b1;
        step();
        // R2: unlocked field writes
        phase_tag = "R2";
        run(1500, 1'b0, 4);
        // R3: lock with bit 3 set, then hammer writes (also R4 writable case)
        phase_tag = "R3";
        cfg_write(6'b10_10_1_0);
        run(1000, 1'b1, 2);
        // R4: lock with bit 3 clear, bit 2 must hold
        do_reset();
        phase_tag = "R4";
        cfg_write(6'b00_01_1_0);
        run(500, 1'b1, 2);
        // R5: high window and 1 MB segment, error flag traffic
        do_reset();
        phase_tag = "R5";
        cfg_write(6'b11_00_1_0);
        run(800, 1'b1, 6);
        // R5: set and clear in the same cycle, set wins
        acc_valid = 1'b1; acc_from_cpu = 1'b1; acc_smm = 1'b0; acc_wb = 1'b0;
        acc_addr = 32'hFEEA_0040;
        cfg_wr = 1'b1; cfg_wdata = 6'b00_00_0_1;
        step();
        cfg_wr = 1'b0; acc_valid = 1'b0;
        step();
        // R7: high window with upper 01, no stolen segment (R6 disabled case)
        do_reset();
        phase_tag = "R7";
        cfg_write(6'b01_00_0_0);
        run(500, 1'b0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule